// File: doc/BRIEF.md
# Two-Channel PCM Frame Receiver with Control Latches

This block takes apart a serial frame that carries two voice channels, plus control information for each channel, on a single data line. The bit clock times the frame and a receive sync pulse marks where each frame starts. Every bit is sampled on the falling edge of the bit clock. A frame holds 28 bits. For each channel the frame delivers an 8-bit companded sample, one channel-enable bit and three general-purpose latch bits. The last four bits of the frame carry nothing.

The receiver presents both samples as parallel bytes, together with a one-cycle valid strobe. It drives six held latch outputs and one enable output per channel. No stored field changes until the whole frame has been shifted in. A frame that a new sync edge cuts short is thrown away. An active-low global power-down input returns every stored field to zero and abandons any frame in progress.

Top module: `pcm_frame_rx`

## Requirements
- R1: A frame starts at the first falling edge of `bclk_i` on which `sync_i` is sampled high after having been sampled low on the previous falling edge; the data bit sampled on that same edge is the most significant bit of the channel-1 sample.
- R2: Frame bit order (1-based): bits 1-8 are the channel-1 sample, MSB first; bit 9 is the channel-1 enable; bits 10-12 are the channel-1 latch bits, with the first received going to `latch_o[2]` and the last to `latch_o[0]`; bits 13-24 repeat this layout for channel 2 (`pcm_o[15:8]`, `ch_en_o[1]`, `latch_o[5:3]`); bits 25-28 are ignored.
- R3: Stored outputs keep their previous values until the 28th bit is sampled. On the falling edge that samples bit 28, all fields update together and `pcm_valid_o` goes high for exactly one bit-clock cycle.
- R4: If a new sync rising edge arrives before bit 28 of a frame, the bit count restarts. The interrupted frame produces no valid pulse and changes no output.
- R5: While `pdn_ni` is sampled low, all of `pcm_o`, `latch_o` and `ch_en_o` are cleared to 0 on that falling edge and `pcm_valid_o` stays low. A frame in progress is abandoned, and bits arriving after power-down is released, with no new sync edge, produce no update.
- R6: Between frames, all outputs hold their last values and `pcm_valid_o` stays low.
- R7: An enable bit of 0 drives that channel's `ch_en_o` bit low; an enable bit of 1 drives it high.
- R8: After `rst_ni` is asserted, all outputs are 0.
- R9: A sync level that stays high for any number of bits starts only one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; data and sync are sampled on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Receive frame sync; its rising edge marks bit 1 |
| data_i | input | 1 | Serial frame data |
| pdn_ni | input | 1 | Global power-down, active low; clears all stored fields |
| pcm_o | output | 16 | Channel samples; channel c at bits [8c+7:8c] |
| pcm_valid_o | output | 1 | One-cycle pulse when a complete frame has been committed |
| latch_o | output | 6 | General-purpose latch outputs, three per channel |
| ch_en_o | output | 2 | Per-channel enable (1 = operate, 0 = powered down) |

## Verification
Every cycle, the assertions check four things: the valid strobe lasts a single cycle; a commit occurs exactly 28 bit edges after a sync rise; power-down clears every field on the next edge; and the outputs never move without a valid strobe. The bench's scenarios show the rest. They check the bit-to-field mapping across all 64 latch patterns, with varying samples, enables, trailing bits and sync widths. They also cover a frame aborted by an early sync, a frame broken by power-down, and holding of the outputs through long idle gaps.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  // width of one channel group: sample, enable bit, latch bits
  function automatic int grp_width(input int pcm_w, input int lat_w);
    return pcm_w + 1 + lat_w;
  endfunction
endpackage

// File: rtl/pcm_rx_sync_det.sv
module pcm_rx_sync_det (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic sync_q;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;
endmodule

// File: rtl/pcm_rx_frame_ctr.sv
module pcm_rx_frame_ctr #(
  parameter int FRAME_BITS = 28,
  parameter int USED_BITS  = 24
) (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic pdn_ni,
  input  logic rise_i,
  output logic shift_en_o,
  output logic done_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST  = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] USED  = CW'(USED_BITS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] bit_idx;
  logic          active;

  always_comb begin
    bit_idx    = rise_i ? CW'(1) : cnt_q + CW'(1);
    active     = rise_i | (cnt_q != '0);
    shift_en_o = pdn_ni & active & (bit_idx <= USED);
    done_o     = pdn_ni & ~rise_i & (cnt_q == LAST);
  end

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!pdn_ni)        cnt_q <= '0;
    else if (rise_i)         cnt_q <= CW'(1);
    else if (done_o)         cnt_q <= '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
  parameter int W = 24
) (
  input  logic         bclk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         data_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] sreg_q;

  // view including the bit sampled on this edge, for a commit on the same edge
  assign next_o = shift_en_i ? {sreg_q[W-2:0], data_i} : sreg_q;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else         sreg_q <= next_o;
  end
endmodule

// File: rtl/pcm_rx_chan_regs.sv
module pcm_rx_chan_regs #(
  parameter int PCM_W = 8,
  parameter int LAT_W = 3,
  localparam int GW   = pcm_rx_pkg::grp_width(PCM_W, LAT_W)
) (
  input  logic             bclk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [GW-1:0]    grp_i,
  output logic [PCM_W-1:0] pcm_o,
  output logic             en_o,
  output logic [LAT_W-1:0] lat_o
);
  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcm_o <= '0;
      en_o  <= 1'b0;
      lat_o <= '0;
    end else if (clr_i) begin
      pcm_o <= '0;
      en_o  <= 1'b0;
      lat_o <= '0;
    end else if (load_i) begin
      pcm_o <= grp_i[GW-1 -: PCM_W];
      en_o  <= grp_i[LAT_W];
      lat_o <= grp_i[LAT_W-1:0];
    end
  end
endmodule

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx #(
  parameter int PCM_W      = 8,
  parameter int LAT_W      = 3,
  parameter int CH_N       = 2,
  parameter int FRAME_BITS = 28
) (
  input  logic                  bclk_i,
  input  logic                  rst_ni,
  input  logic                  sync_i,
  input  logic                  data_i,
  input  logic                  pdn_ni,
  output logic [CH_N*PCM_W-1:0] pcm_o,
  output logic                  pcm_valid_o,
  output logic [CH_N*LAT_W-1:0] latch_o,
  output logic [CH_N-1:0]       ch_en_o
);
  localparam int GW   = pcm_rx_pkg::grp_width(PCM_W, LAT_W);
  localparam int USED = CH_N * GW;

  logic            rise;
  logic            shift_en;
  logic            done;
  logic [USED-1:0] frame_bits;
  logic            valid_q;

  pcm_rx_sync_det u_sync (
    .bclk_i (bclk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .rise_o (rise)
  );

  pcm_rx_frame_ctr #(.FRAME_BITS(FRAME_BITS), .USED_BITS(USED)) u_ctr (
    .bclk_i     (bclk_i),
    .rst_ni     (rst_ni),
    .pdn_ni     (pdn_ni),
    .rise_i     (rise),
    .shift_en_o (shift_en),
    .done_o     (done)
  );

  pcm_rx_shifter #(.W(USED)) u_shift (
    .bclk_i     (bclk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .data_i     (data_i),
    .next_o     (frame_bits)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    pcm_rx_chan_regs #(.PCM_W(PCM_W), .LAT_W(LAT_W)) u_regs (
      .bclk_i (bclk_i),
      .rst_ni (rst_ni),
      .clr_i  (~pdn_ni),
      .load_i (done),
      .grp_i  (frame_bits[USED-1-c*GW -: GW]),
      .pcm_o  (pcm_o[c*PCM_W +: PCM_W]),
      .en_o   (ch_en_o[c]),
      .lat_o  (latch_o[c*LAT_W +: LAT_W])
    );
  end

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= done;
  end

  assign pcm_valid_o = valid_q;
endmodule

// File: rtl/pcm_frame_rx_chk.sv
module pcm_frame_rx_chk #(
  parameter int PCM_W      = 8,
  parameter int LAT_W      = 3,
  parameter int CH_N       = 2,
  parameter int FRAME_BITS = 28
) (
  input logic                  bclk_i,
  input logic                  rst_ni,
  input logic                  sync_i,
  input logic                  pdn_ni,
  input logic [CH_N*PCM_W-1:0] pcm_o,
  input logic                  pcm_valid_o,
  input logic [CH_N*LAT_W-1:0] latch_o,
  input logic [CH_N-1:0]       ch_en_o
);
  localparam int SW = $clog2(FRAME_BITS + 2) + 1;
  localparam logic [SW-1:0] SMAX = '1;

  logic          sync_prev;
  logic [SW-1:0] since_rise;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev  <= 1'b0;
      since_rise <= SMAX;
    end else begin
      sync_prev <= sync_i;
      if (sync_i && !sync_prev)  since_rise <= SW'(1);
      else if (since_rise != SMAX) since_rise <= since_rise + SW'(1);
    end
  end

  // R3
  valid_pulse_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    pcm_valid_o |=> !pcm_valid_o);

  // R3
  frame_len_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    pcm_valid_o |-> (since_rise == SW'(FRAME_BITS)));

  // R5
  pdn_clear_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    !pdn_ni |=> (pcm_o == '0 && latch_o == '0 && ch_en_o == '0 && !pcm_valid_o));

  // R6
  hold_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    pdn_ni |=> (pcm_valid_o || ($stable(pcm_o) && $stable(latch_o) && $stable(ch_en_o))));
endmodule

bind pcm_frame_rx pcm_frame_rx_chk #(
  .PCM_W(PCM_W), .LAT_W(LAT_W), .CH_N(CH_N), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .bclk_i      (bclk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_i),
  .pdn_ni      (pdn_ni),
  .pcm_o       (pcm_o),
  .pcm_valid_o (pcm_valid_o),
  .latch_o     (latch_o),
  .ch_en_o     (ch_en_o)
);

// File: tb/pcm_frame_rx_tb.sv
module pcm_frame_rx_tb;
  logic        bclk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_r = 1'b0;
  logic        data_r = 1'b0;
  logic        pdn_r = 1'b1;
  logic [15:0] pcm;
  logic        valid;
  logic [5:0]  latch;
  logic [1:0]  ch_en;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;

  always #4 bclk = ~bclk;

  pcm_frame_rx u_dut (
    .bclk_i      (bclk),
    .rst_ni      (rst_ni),
    .sync_i      (sync_r),
    .data_i      (data_r),
    .pdn_ni      (pdn_r),
    .pcm_o       (pcm),
    .pcm_valid_o (valid),
    .latch_o     (latch),
    .ch_en_o     (ch_en)
  );

  always @(posedge bclk) if (valid) vcount++;

  task automatic step();
    @(posedge bclk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] mk_frame(input logic [7:0] p1, input logic e1, input logic [2:0] l1,
                                           input logic [7:0] p2, input logic e2, input logic [2:0] l2,
                                           input logic [3:0] tail);
    return {p1, e1, l1, p2, e2, l2, tail};
  endfunction

  // drive frame bits [first..last] (0-based), sync high for bit indices below sl
  task automatic drive_bits(input logic [27:0] f, input int first, input int last, input int sl);
    for (int b = first; b <= last; b++) begin
      step();
      sync_r = (b < sl);
      data_r = f[27-b];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      step();
      sync_r = 1'b0;
      data_r = 1'b0;
    end
  endtask

  task automatic chk_out(input string tag, input logic [15:0] ep, input logic [5:0] el, input logic [1:0] ee);
    chk(pcm == ep,   tag, 32'(pcm),   32'(ep));
    chk(latch == el, tag, 32'(latch), 32'(el));
    chk(ch_en == ee, tag, 32'(ch_en), 32'(ee));
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] ep;
    logic [5:0]  el;
    logic [1:0]  ee;
    int          v0;
    logic [27:0] fa;
    logic [27:0] fb;

    repeat (3) step();
    // R8 reset state
    chk_out("R8 reset", 16'h0, 6'h0, 2'b0);
    chk(valid == 1'b0, "R8 valid", 32'(valid), 0);
    rst_ni = 1'b1;
    idle(3);

    ep = '0; el = '0; ee = '0;
    // R1 R2 R3 R7 R9: sweep all latch patterns with varied data, tails and sync widths
    for (int i = 0; i < 64; i++) begin
      logic [7:0]  p1, p2;
      logic [2:0]  l1, l2;
      logic [1:0]  en;
      logic [27:0] f;
      p1 = 8'((i * 53 + 17) & 255);
      p2 = 8'((i * 29 + 200) & 255);
      l1 = 3'(i >> 3);
      l2 = 3'(i & 7);
      en = 2'((i ^ (i >> 4)) & 3);
      f  = mk_frame(p1, en[0], l1, p2, en[1], l2, 4'(i & 15));
      v0 = vcount;
      drive_bits(f, 0, 26, 1 + (i % 27));
      step();
      // R3: 27 bits in, nothing committed yet
      chk_out("R3 before last bit", ep, el, ee);
      chk(vcount == v0, "R3 early valid", 32'(vcount), 32'(v0));
      sync_r = 1'b0;
      data_r = f[0];
      step();
      ep = {p2, p1}; el = {l2, l1}; ee = en;
      chk_out("R2 R7 fields", ep, el, ee);
      chk(vcount == v0 + 1, "R3 R9 one valid", 32'(vcount), 32'(v0 + 1));
      idle(2 + (i % 5));
      // R6 hold and single-cycle strobe
      chk_out("R6 hold", ep, el, ee);
      chk(vcount == v0 + 1, "R6 no extra valid", 32'(vcount), 32'(v0 + 1));
    end

    // R9: sync held high through a frame and far beyond
    fa = mk_frame(8'hA5, 1'b1, 3'b101, 8'h3C, 1'b0, 3'b010, 4'hF);
    v0 = vcount;
    drive_bits(fa, 0, 27, 28);
    for (int k = 0; k < 40; k++) begin step(); sync_r = 1'b1; data_r = k[0]; end
    idle(2);
    chk(vcount == v0 + 1, "R9 long sync", 32'(vcount), 32'(v0 + 1));
    chk_out("R9 long sync fields", 16'h3CA5, 6'b010101, 2'b01);
    ep = 16'h3CA5; el = 6'b010101; ee = 2'b01;

    // R4: early sync restarts and discards the partial frame
    fa = mk_frame(8'h11, 1'b0, 3'b111, 8'h22, 1'b0, 3'b111, 4'h0);
    fb = mk_frame(8'hF0, 1'b1, 3'b011, 8'h0F, 1'b1, 3'b100, 4'h5);
    v0 = vcount;
    drive_bits(fa, 0, 14, 4);
    idle(1);
    step();
    chk_out("R4 partial ignored", ep, el, ee);
    chk(vcount == v0, "R4 partial valid", 32'(vcount), 32'(v0));
    sync_r = 1'b1; data_r = fb[27];
    drive_bits(fb, 1, 27, 3);
    step();
    chk_out("R4 restarted frame", 16'h0FF0, 6'b100011, 2'b11);
    chk(vcount == v0 + 1, "R4 valid count", 32'(vcount), 32'(v0 + 1));
    idle(3);

    // R5: power-down clears everything
    pdn_r = 1'b0;
    step();
    chk_out("R5 cleared", 16'h0, 6'h0, 2'b0);
    pdn_r = 1'b1;
    idle(2);

    // R5: power-down inside a frame abandons it
    v0 = vcount;
    drive_bits(fb, 0, 9, 5);
    step(); pdn_r = 1'b0;
    step(); pdn_r = 1'b1;
    drive_bits(fb, 12, 27, 0);
    idle(3);
    chk_out("R5 abandoned frame", 16'h0, 6'h0, 2'b0);
    chk(vcount == v0, "R5 no valid", 32'(vcount), 32'(v0));

    // R5: power-down held through a whole frame
    pdn_r = 1'b0;
    drive_bits(fb, 0, 27, 6);
    idle(2);
    chk(vcount == v0, "R5 frame while down", 32'(vcount), 32'(v0));
    chk_out("R5 stays clear", 16'h0, 6'h0, 2'b0);
    pdn_r = 1'b1;
    idle(2);

    // R1: reception resumes on the next sync edge
    drive_bits(fa, 0, 27, 2);
    idle(1);
    chk_out("R1 resume", 16'h2211, 6'b111111, 2'b00);
    chk(vcount == v0 + 1, "R1 resume valid", 32'(vcount), 32'(v0 + 1));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule